// File: doc/BRIEF.md
# Per-Channel Fault Diagnostic Register

This block collects fault reports from a bank of output channels. Each channel delivers four raw comparator levels: open load, short to ground, short to battery and over-temperature. Each level must stay asserted for a programmable number of clock cycles before it counts as a confirmed fault. A confirmed fault overwrites the channel's 2-bit diagnostic code, so each code always shows the most recent fault to pass its filter. Two sticky summary flags sit alongside the codes. One records that any fault was confirmed on any channel, and one records a confirmed over-temperature.

A host reads the diagnostics one word at a time. The channel codes are packed into words of `CH_PER_WORD` channels, and one further word carries the two summary flags. A read request returns the selected word one cycle later. In the same clock edge that captures the word, the word is cleared. The host therefore sees the contents from before the clear, and a fault that confirms on that edge is still kept.

Top module: `fault_diag_reg`

## Requirements
- R1: After a synchronous reset, every channel code is 2'b11, both summary flags are 0, `rd_valid` is 0 and `rd_data` is 0.
- R2: A raw fault level is confirmed on the `FILT_CYC`-th consecutive rising clock edge at which it is sampled high. A level that is high for fewer consecutive edges leaves the code unchanged.
- R3: Channel codes are 2'b11 for no fault, 2'b10 for open load, 2'b01 for short to ground and 2'b00 for short to battery or over-temperature.
- R4: A later confirmed fault on a channel replaces the code left by an earlier one.
- R5: When several kinds confirm on one channel at the same edge, short to battery or over-temperature (2'b00) wins over short to ground, which wins over open load.
- R6: A raw level that stays high produces only one confirmation. A new confirmation needs the level to drop first and then pass the filter again.
- R7: Channel word w holds channel w*CH_PER_WORD+k at bits [2k+1:2k]. Bit positions with no channel read as 0. With the defaults there are three channel words at addresses 0 to 2, and the last holds channels 16 and 17 in bits [3:0].
- R8: A read request with `rd_addr` raises `rd_valid` for exactly one cycle, on the next edge. `rd_data` then carries the word's contents from before the request, and that word is reset to the no-fault code.
- R9: A read clears only the addressed word. Codes in other words keep their values.
- R10: The status word sits at address `NUM_WORDS` (3 with the defaults). Bit 0 is the any-fault flag and bit 1 is the over-temperature flag; all other bits read 0. Reading this word clears both flags, and any later confirmation sets them again.
- R11: A fault that confirms on the same edge as a read clear is stored after the clear. The new code, or the re-set flag, is visible to the next read and not to the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_open | input | NUM_CH | Raw open-load level per channel |
| raw_gnd | input | NUM_CH | Raw short-to-ground level per channel |
| raw_bat | input | NUM_CH | Raw short-to-battery level per channel |
| raw_hot | input | NUM_CH | Raw over-temperature level per channel |
| rd_req | input | 1 | Read request, one cycle per read |
| rd_addr | input | ADDR_W | Word address: channel words, then the status word |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | 2*CH_PER_WORD | Word contents captured before the clear |

## Verification
The assertions are checked on every cycle. They cover:
- the one-cycle response of `rd_valid`;
- the code each kind of confirmation writes, and the priority among kinds;
- that a level rising from low is never confirmed on its first edge;
- that a channel's code holds when it has neither a confirmation nor a read of its word;
- the set, hold and clear rules of the two flags.

The bench scenarios are the only way to show the rest:
- that pulses shorter than the filter time are ignored;
- that a level held high is not reported again;
- that the channels sit at the right bit positions in each word;
- that data returned by a read is the pre-clear content;
- what happens when a confirmation and a read clear fall on the same edge.

// File: rtl/diag_pkg.sv
package diag_pkg;

  typedef enum logic [1:0] {
    CODE_BAT_HOT = 2'b00,
    CODE_GND     = 2'b01,
    CODE_OPEN    = 2'b10,
    CODE_NONE    = 2'b11
  } diag_code_e;

  localparam int KIND_OPEN = 0;
  localparam int KIND_GND  = 1;
  localparam int KIND_BAT  = 2;
  localparam int KIND_HOT  = 3;
  localparam int NUM_KINDS = 4;

  localparam int FLAG_ANY_BIT = 0;
  localparam int FLAG_HOT_BIT = 1;

endpackage

// File: rtl/diag_filter.sv
// Persistence filter for a vector of raw fault levels. Each lane counts
// consecutive high samples and reports a one-cycle confirm when the count
// reaches FILT_CYC. The counter then saturates until the level drops.
module diag_filter #(
  parameter int LANES    = 18,
  parameter int FILT_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] raw,
  output logic [LANES-1:0] confirm
);

  localparam int CNT_W = $clog2(FILT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FILT_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYC - 1);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q <= '0;
      end else if (!raw[l]) begin
        cnt_q <= '0;
      end else if (cnt_q != CNT_SAT) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end

    assign confirm[l] = raw[l] && (cnt_q == CNT_LAST);
  end

endmodule

// File: rtl/diag_store.sv
// Holds the per-channel codes and the summary flags, packs them into words
// and serves clear-on-read accesses.
module diag_store
  import diag_pkg::*;
#(
  parameter int NUM_CH      = 18,
  parameter int CH_PER_WORD = 8
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [NUM_CH-1:0]                     conf_open,
  input  logic [NUM_CH-1:0]                     conf_gnd,
  input  logic [NUM_CH-1:0]                     conf_bat,
  input  logic [NUM_CH-1:0]                     conf_hot,
  input  logic                                  rd_req,
  input  logic [$clog2((NUM_CH+CH_PER_WORD-1)/CH_PER_WORD+1)-1:0] rd_addr,
  output logic                                  rd_valid,
  output logic [2*CH_PER_WORD-1:0]              rd_data,
  output logic [2*NUM_CH-1:0]                   codes_flat,
  output logic                                  flag_any,
  output logic                                  flag_hot
);

  localparam int WORD_W    = 2 * CH_PER_WORD;
  localparam int NUM_WORDS = (NUM_CH + CH_PER_WORD - 1) / CH_PER_WORD;
  localparam int ADDR_W    = $clog2(NUM_WORDS + 1);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_WORDS);

  logic [1:0]        code_q [NUM_CH];
  logic [WORD_W-1:0] words  [NUM_WORDS];
  logic [WORD_W-1:0] rd_mux;
  logic              stat_clr;

  assign stat_clr = rd_req && (rd_addr == STAT_ADDR);

  // Per-channel update: a read clear comes first, then any confirmation
  // on the same edge overrides it so the new fault is kept.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] MY_WORD = ADDR_W'(c / CH_PER_WORD);
    logic       clr;
    logic [1:0] code_nxt;

    assign clr = rd_req && (rd_addr == MY_WORD);

    always_comb begin
      code_nxt = code_q[c];
      if (clr) code_nxt = CODE_NONE;
      if (conf_bat[c] || conf_hot[c]) code_nxt = CODE_BAT_HOT;
      else if (conf_gnd[c])           code_nxt = CODE_GND;
      else if (conf_open[c])          code_nxt = CODE_OPEN;
    end

    always_ff @(posedge clk) begin
      if (rst) code_q[c] <= CODE_NONE;
      else     code_q[c] <= code_nxt;
    end

    assign codes_flat[2*c +: 2] = code_q[c];
  end

  // Word packing; positions without a channel read as zero.
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    for (genvar k = 0; k < CH_PER_WORD; k++) begin : g_slot
      if (w * CH_PER_WORD + k < NUM_CH) begin : g_used
        assign words[w][2*k +: 2] = code_q[w*CH_PER_WORD + k];
      end else begin : g_pad
        assign words[w][2*k +: 2] = 2'b00;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (rd_addr == ADDR_W'(w)) rd_mux = words[w];
    end
    if (rd_addr == STAT_ADDR) begin
      rd_mux[FLAG_ANY_BIT] = flag_any;
      rd_mux[FLAG_HOT_BIT] = flag_hot;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_any <= 1'b0;
      flag_hot <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_mux;
      flag_any <= (flag_any && !stat_clr) ||
                  (|{conf_open, conf_gnd, conf_bat, conf_hot});
      flag_hot <= (flag_hot && !stat_clr) || (|conf_hot);
    end
  end

endmodule

// File: rtl/fault_diag_reg.sv
module fault_diag_reg
  import diag_pkg::*;
#(
  parameter int NUM_CH      = 18,
  parameter int FILT_CYC    = 4,
  parameter int CH_PER_WORD = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH-1:0]        raw_open,
  input  logic [NUM_CH-1:0]        raw_gnd,
  input  logic [NUM_CH-1:0]        raw_bat,
  input  logic [NUM_CH-1:0]        raw_hot,
  input  logic                     rd_req,
  input  logic [$clog2((NUM_CH+CH_PER_WORD-1)/CH_PER_WORD+1)-1:0] rd_addr,
  output logic                     rd_valid,
  output logic [2*CH_PER_WORD-1:0] rd_data
);

  logic [NUM_CH-1:0] raw_kind  [NUM_KINDS];
  logic [NUM_CH-1:0] conf_kind [NUM_KINDS];
  logic [NUM_CH-1:0] conf_open, conf_gnd, conf_bat, conf_hot;
  logic [2*NUM_CH-1:0] codes_flat;
  logic flag_any, flag_hot;

  assign raw_kind[KIND_OPEN] = raw_open;
  assign raw_kind[KIND_GND]  = raw_gnd;
  assign raw_kind[KIND_BAT]  = raw_bat;
  assign raw_kind[KIND_HOT]  = raw_hot;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    diag_filter #(
      .LANES    (NUM_CH),
      .FILT_CYC (FILT_CYC)
    ) u_filt (
      .clk     (clk),
      .rst     (rst),
      .raw     (raw_kind[k]),
      .confirm (conf_kind[k])
    );
  end

  assign conf_open = conf_kind[KIND_OPEN];
  assign conf_gnd  = conf_kind[KIND_GND];
  assign conf_bat  = conf_kind[KIND_BAT];
  assign conf_hot  = conf_kind[KIND_HOT];

  diag_store #(
    .NUM_CH      (NUM_CH),
    .CH_PER_WORD (CH_PER_WORD)
  ) u_store (
    .clk        (clk),
    .rst        (rst),
    .conf_open  (conf_open),
    .conf_gnd   (conf_gnd),
    .conf_bat   (conf_bat),
    .conf_hot   (conf_hot),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .codes_flat (codes_flat),
    .flag_any   (flag_any),
    .flag_hot   (flag_hot)
  );

endmodule

// File: rtl/fault_diag_reg_chk.sv
module fault_diag_reg_chk #(
  parameter int NUM_CH      = 18,
  parameter int FILT_CYC    = 4,
  parameter int CH_PER_WORD = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_CH-1:0]   raw_gnd,
  input logic [NUM_CH-1:0]   conf_open,
  input logic [NUM_CH-1:0]   conf_gnd,
  input logic [NUM_CH-1:0]   conf_bat,
  input logic [NUM_CH-1:0]   conf_hot,
  input logic                rd_req,
  input logic [$clog2((NUM_CH+CH_PER_WORD-1)/CH_PER_WORD+1)-1:0] rd_addr,
  input logic                rd_valid,
  input logic [2*NUM_CH-1:0] codes_flat,
  input logic                flag_any,
  input logic                flag_hot
);

  localparam int NUM_WORDS = (NUM_CH + CH_PER_WORD - 1) / CH_PER_WORD;
  localparam int ADDR_W    = $clog2(NUM_WORDS + 1);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_WORDS);

  logic any_conf;
  logic stat_rd;
  assign any_conf = |{conf_open, conf_gnd, conf_bat, conf_hot};
  assign stat_rd  = rd_req && (rd_addr == STAT_ADDR);

  p_valid_follows_r8: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);
  p_valid_single_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_valid);
  p_flags_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !any_conf) |=> (!flag_any && !flag_hot));
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (flag_any && !stat_rd) |=> flag_any);
  p_any_set_r11: assert property (@(posedge clk) disable iff (rst)
    any_conf |=> flag_any);
  p_hot_set_r11: assert property (@(posedge clk) disable iff (rst)
    (|conf_hot) |=> flag_hot);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] MY_WORD = ADDR_W'(c / CH_PER_WORD);

    p_top_prio_r5: assert property (@(posedge clk) disable iff (rst)
      (conf_bat[c] || conf_hot[c]) |=> (codes_flat[2*c +: 2] == 2'b00));
    p_gnd_code_r3: assert property (@(posedge clk) disable iff (rst)
      (conf_gnd[c] && !conf_bat[c] && !conf_hot[c])
        |=> (codes_flat[2*c +: 2] == 2'b01));
    p_open_code_r3: assert property (@(posedge clk) disable iff (rst)
      (conf_open[c] && !conf_gnd[c] && !conf_bat[c] && !conf_hot[c])
        |=> (codes_flat[2*c +: 2] == 2'b10));
    p_hold_code_r9: assert property (@(posedge clk) disable iff (rst)
      (!conf_open[c] && !conf_gnd[c] && !conf_bat[c] && !conf_hot[c] &&
       !(rd_req && rd_addr == MY_WORD))
        |=> $stable(codes_flat[2*c +: 2]));
    if (FILT_CYC >= 2) begin : g_filt
      p_no_early_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(raw_gnd[c]) |-> !conf_gnd[c]);
    end
  end

endmodule

bind fault_diag_reg fault_diag_reg_chk #(
  .NUM_CH      (NUM_CH),
  .FILT_CYC    (FILT_CYC),
  .CH_PER_WORD (CH_PER_WORD)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .raw_gnd    (raw_gnd),
  .conf_open  (conf_open),
  .conf_gnd   (conf_gnd),
  .conf_bat   (conf_bat),
  .conf_hot   (conf_hot),
  .rd_req     (rd_req),
  .rd_addr    (rd_addr),
  .rd_valid   (rd_valid),
  .codes_flat (codes_flat),
  .flag_any   (flag_any),
  .flag_hot   (flag_hot)
);

// File: tb/fault_diag_reg_bench.sv
module fault_diag_reg_bench;

  localparam int NUM_CH      = 18;
  localparam int FILT_CYC    = 4;
  localparam int CH_PER_WORD = 8;
  localparam int NUM_WORDS   = (NUM_CH + CH_PER_WORD - 1) / CH_PER_WORD;
  localparam int ADDR_W      = $clog2(NUM_WORDS + 1);
  localparam int WORD_W      = 2 * CH_PER_WORD;
  localparam int STAT        = NUM_WORDS;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NUM_CH-1:0] raw_open = '0;
  logic [NUM_CH-1:0] raw_gnd  = '0;
  logic [NUM_CH-1:0] raw_bat  = '0;
  logic [NUM_CH-1:0] raw_hot  = '0;
  logic              rd_req = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic              rd_valid;
  logic [WORD_W-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [WORD_W-1:0] exp_q [$];
  string             tag_q [$];

  always #2.5 clk = ~clk;

  fault_diag_reg #(
    .NUM_CH      (NUM_CH),
    .FILT_CYC    (FILT_CYC),
    .CH_PER_WORD (CH_PER_WORD)
  ) u_fault_diag_reg (
    .clk      (clk),
    .rst      (rst),
    .raw_open (raw_open),
    .raw_gnd  (raw_gnd),
    .raw_bat  (raw_bat),
    .raw_hot  (raw_hot),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  // Monitor: pops one expected word per valid read result.
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected rd_valid data=%h expected no result", rd_data);
      end else begin
        logic [WORD_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", t, rd_data, e);
        end
      end
    end
  end

  // Driver: issue a read and queue its expected word.
  task automatic issue_rd(input int addr, input logic [WORD_W-1:0] e, input string t);
    rd_req  = 1'b1;
    rd_addr = ADDR_W'(addr);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic rd(input int addr, input logic [WORD_W-1:0] e, input string t);
    issue_rd(addr, e, t);
    @(negedge clk);
  endtask

  task automatic set_raw(input int kind, input int ch, input logic v);
    case (kind)
      0: raw_open[ch] = v;
      1: raw_gnd[ch]  = v;
      2: raw_bat[ch]  = v;
      default: raw_hot[ch] = v;
    endcase
  endtask

  task automatic pulse(input int kind, input int ch, input int n);
    set_raw(kind, ch, 1'b1);
    repeat (n) @(negedge clk);
    set_raw(kind, ch, 1'b0);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state at the ports
    checks++;
    if (rd_valid !== 1'b0 || rd_data !== '0) begin
      errors++;
      $display("FAIL R1 actual valid=%b data=%h expected valid=0 data=0000", rd_valid, rd_data);
    end
    rd(0, 16'hFFFF, "R1 word0 after reset");
    rd(1, 16'hFFFF, "R1 word1 after reset");
    rd(2, 16'h000F, "R7 word2 padding after reset");
    rd(STAT, 16'h0000, "R1 status after reset");

    // R2: pulse one cycle short of the filter is ignored
    pulse(0, 1, FILT_CYC - 1);
    rd(0, 16'hFFFF, "R2 short pulse ignored");
    rd(STAT, 16'h0000, "R2 short pulse sets no flag");

    // R2/R3/R8: full-length open load on ch1
    pulse(0, 1, FILT_CYC);
    rd(0, 16'hFFFB, "R3 open load code ch1");
    rd(0, 16'hFFFF, "R8 word cleared by read");
    rd(STAT, 16'h0001, "R10 any-fault flag set");
    rd(STAT, 16'h0000, "R10 flags cleared by read");

    // R9: clearing word1 leaves word0 intact
    pulse(1, 0, FILT_CYC);
    pulse(2, 8, FILT_CYC);
    rd(1, 16'hFFFC, "R7 battery short ch8 in word1");
    rd(0, 16'hFFFD, "R9 word0 kept after word1 read");
    rd(1, 16'hFFFF, "R9 word1 cleared");
    rd(STAT, 16'h0001, "R10 flag after ch0/ch8");

    // R4: later fault replaces earlier one
    pulse(1, 9, FILT_CYC);
    pulse(0, 9, FILT_CYC);
    rd(1, 16'hFFFB, "R4 open load overwrites ground short ch9");
    rd(STAT, 16'h0001, "R10 flag after ch9");

    // R5: simultaneous confirmations on one channel
    raw_gnd[17] = 1'b1; raw_open[17] = 1'b1;
    raw_hot[16] = 1'b1; raw_gnd[16] = 1'b1; raw_open[16] = 1'b1;
    repeat (FILT_CYC) @(negedge clk);
    raw_gnd = '0; raw_open = '0; raw_hot = '0;
    @(negedge clk);
    rd(2, 16'h0004, "R5 priority ch16 hot, ch17 ground");
    rd(STAT, 16'h0003, "R10 over-temperature flag");
    rd(STAT, 16'h0000, "R10 both flags cleared");

    // R6: a level held high reports once
    raw_open[3] = 1'b1;
    repeat (FILT_CYC + 2) @(negedge clk);
    rd(0, 16'hFFBF, "R6 first report ch3");
    repeat (3) @(negedge clk);
    rd(0, 16'hFFFF, "R6 no repeat while held");
    raw_open[3] = 1'b0;
    @(negedge clk);
    pulse(0, 3, FILT_CYC);
    rd(0, 16'hFFBF, "R6 re-armed after drop");
    rd(STAT, 16'h0001, "R10 flag after ch3");

    // R11: confirmation on the same edge as a status read
    raw_gnd[2] = 1'b1;
    repeat (FILT_CYC - 1) @(negedge clk);
    issue_rd(STAT, 16'h0000, "R11 status read returns pre-clear");
    raw_gnd[2] = 1'b0;
    @(negedge clk);
    rd(STAT, 16'h0001, "R11 flag set after clear kept");
    rd(0, 16'hFFDF, "R3 ground short code ch2");

    // R11: confirmation on the same edge as a word read
    raw_open[4] = 1'b1;
    repeat (FILT_CYC - 1) @(negedge clk);
    issue_rd(0, 16'hFFFF, "R11 word read returns pre-clear");
    raw_open[4] = 1'b0;
    @(negedge clk);
    rd(0, 16'hFEFF, "R11 new code kept after clear");

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R8 missing results actual=%0d expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule